// File: doc/BRIEF.md
# Block Transfer Address Sequencer

The sequencer takes one multi-register load or store instruction word and the current value of its base register. It turns them into a stream of single-word memory beats. Each beat carries a word address, the number of the register to move, the transfer direction and a bank select. When the stream ends, the block reports the updated base value that the register file should write back.

Before any beat is issued, the decoder rejects encodings whose result is unpredictable. It also resolves the privileged-mode bit into one of two actions: either every beat uses the user-mode register bank, or the status register is restored from its saved copy when the transfer completes. A data abort on any beat stops the transfer at once and cancels the base writeback. Each accepted start ends in exactly one single-cycle done pulse, whether the transfer completes normally, aborts or is rejected.

Top module: `blk_xfer_seq`

## Requirements
- R1: When the base register field (bits 19:16) equals 15, the block asserts `unpred_o` in the done cycle and issues no memory beat.
- R2: When the register list (bits 15:0) is all zero, the block asserts `unpred_o` in the done cycle and issues no memory beat.
- R3: When the privileged bit (bit 22) and the writeback bit (bit 21) are both set and list bit 15 is clear, the block asserts `unpred_o` in the done cycle and issues no memory beat.
- R4: The block issues exactly n beats, where n is the number of set list bits. Beats run in ascending register order, and each address is 4 above the previous one. Address and register number stay stable while `mem_ready_i` is low. The block advances only on a beat where `mem_valid_o` and `mem_ready_i` are both high.
- R5: With bit 23 set (up) and bit 24 set (before), the first address is base+4.
- R6: With bit 23 set and bit 24 clear, the first address is base.
- R7: With bit 23 clear and bit 24 set, the first address is base-4n.
- R8: With bit 23 clear and bit 24 clear, the first address is base-4(n-1).
- R9: In the done cycle, `wb_en_o` is high exactly when bit 21 is set. `wb_val_o` is then base+4n when bit 23 is set and base-4n when it is clear.
- R10: `user_bank_o` is high on every beat exactly when bit 22 is set and either the transfer is a store (bit 20 clear) or list bit 15 is clear.
- R11: For a load (bit 20 set) with bit 22 set and list bit 15 set, `status_restore_o` is high in the done cycle and `user_bank_o` is low.
- R12: A beat accepted with `mem_abort_i` high ends the transfer. No further beats follow, and the done cycle shows `abort_o` high with `wb_en_o` and `status_restore_o` low.
- R13: `done_o` is a single-cycle pulse, one per accepted start. `load_o` equals bit 20 on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept instruction and base (sampled when idle) |
| insn_i | input | 32 | Block transfer instruction word |
| base_i | input | 32 | Base register value |
| mem_valid_o | output | 1 | Beat request valid |
| mem_ready_i | input | 1 | Memory accepts the current beat |
| mem_abort_i | input | 1 | Data abort for the accepted beat |
| addr_o | output | 32 | Word address of the current beat |
| reg_idx_o | output | 4 | Register number of the current beat |
| load_o | output | 1 | 1 = load, 0 = store |
| user_bank_o | output | 1 | Use the user-mode register bank |
| status_restore_o | output | 1 | Restore status from saved status (done cycle) |
| wb_en_o | output | 1 | Write back the base register (done cycle) |
| wb_val_o | output | 32 | Written-back base value |
| unpred_o | output | 1 | Unpredictable encoding rejected (done cycle) |
| abort_o | output | 1 | Transfer ended by abort (done cycle) |
| done_o | output | 1 | Single-cycle completion pulse |

## Verification
The hardest case to reach is an abort in the middle of a long writeback transfer with memory stalls. Reaching it needs an accepted abort on a beat other than the first or last, with earlier beats held across stalled cycles. The bench drives `mem_ready_i` on alternating cycles and raises `mem_abort_i` only on the chosen accepted beat. It then checks that no further beat appears and that the writeback and status-restore outputs stay low. Decrement-after with a single register is also covered, because there the first address equals the base itself.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  localparam int INSN_W = 32;
  localparam int RN_LSB = 16;
  localparam int L_BIT  = 20;
  localparam int W_BIT  = 21;
  localparam int S_BIT  = 22;
  localparam int U_BIT  = 23;
  localparam int P_BIT  = 24;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/blk_xfer_decode.sv
module blk_xfer_decode
  import blk_xfer_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int CNT_W = $clog2(NREG + 1)
) (
  input  logic [INSN_W-1:0] insn_i,
  output logic [NREG-1:0]   list_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              up_o,
  output logic              pre_o,
  output logic              wb_o,
  output logic              load_o,
  output logic              user_bank_o,
  output logic              restore_o,
  output logic              unpred_o
);
  logic       s_bit;
  logic       top_reg;
  logic [3:0] rn;
  logic       unused_hi;

  assign unused_hi = ^insn_i[INSN_W-1:P_BIT+1];

  assign list_o  = insn_i[NREG-1:0];
  assign rn      = insn_i[RN_LSB +: 4];
  assign s_bit   = insn_i[S_BIT];
  assign top_reg = list_o[NREG-1];
  assign up_o    = insn_i[U_BIT];
  assign pre_o   = insn_i[P_BIT];
  assign wb_o    = insn_i[W_BIT];
  assign load_o  = insn_i[L_BIT];

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < NREG; i++) cnt_o = cnt_o + CNT_W'(list_o[i]);
  end

  // privileged bit: restore status on load with pc, else user bank
  assign restore_o   = s_bit & load_o & top_reg;
  assign user_bank_o = s_bit & ~(load_o & top_reg);

  assign unpred_o = (rn == 4'hF) | (list_o == '0) | (s_bit & wb_o & ~top_reg);
endmodule

// File: rtl/blk_xfer_addr.sv
module blk_xfer_addr #(
  parameter int AW    = 32,
  parameter int CNT_W = 5,
  parameter int STEP  = 4
) (
  input  logic [AW-1:0]    base_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             up_i,
  input  logic             pre_i,
  output logic [AW-1:0]    first_o,
  output logic [AW-1:0]    final_o
);
  logic [AW-1:0] span;
  logic [AW-1:0] low;

  assign span = AW'(cnt_i) * AW'(STEP);
  assign low  = base_i - span;

  always_comb begin
    if (up_i) begin
      first_o = pre_i ? base_i + AW'(STEP) : base_i;
      final_o = base_i + span;
    end else begin
      first_o = pre_i ? low : low + AW'(STEP);
      final_o = low;
    end
  end
endmodule

// File: rtl/blk_xfer_pick.sv
module blk_xfer_pick #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  list_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [NREG-1:0]  rest_o,
  output logic             last_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (list_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign rest_o = list_i & (list_i - NREG'(1));
  assign last_o = (rest_o == '0);
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NREG  = 16,
  parameter int STEP  = 4,
  localparam int IDX_W = $clog2(NREG),
  localparam int CNT_W = $clog2(NREG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [AW-1:0]     base_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  input  logic              mem_abort_i,
  output logic [AW-1:0]     addr_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic              load_o,
  output logic              user_bank_o,
  output logic              status_restore_o,
  output logic              wb_en_o,
  output logic [AW-1:0]     wb_val_o,
  output logic              unpred_o,
  output logic              abort_o,
  output logic              done_o
);
  seq_state_e state_q;

  logic [NREG-1:0]  dec_list;
  logic [CNT_W-1:0] dec_cnt;
  logic dec_up, dec_pre, dec_wb, dec_load, dec_user, dec_restore, dec_unpred;
  logic [AW-1:0]    first_addr, final_addr;

  logic [NREG-1:0]  pend_q, pick_rest;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_last;
  logic [AW-1:0]    addr_q, wb_val_q;
  logic load_q, user_q, restore_q, wb_q, unpred_q, abort_q;
  logic fin, clean, beat_go;

  blk_xfer_decode #(.NREG(NREG), .CNT_W(CNT_W)) i_decode (
    .insn_i      (insn_i),
    .list_o      (dec_list),
    .cnt_o       (dec_cnt),
    .up_o        (dec_up),
    .pre_o       (dec_pre),
    .wb_o        (dec_wb),
    .load_o      (dec_load),
    .user_bank_o (dec_user),
    .restore_o   (dec_restore),
    .unpred_o    (dec_unpred)
  );

  blk_xfer_addr #(.AW(AW), .CNT_W(CNT_W), .STEP(STEP)) i_addr (
    .base_i  (base_i),
    .cnt_i   (dec_cnt),
    .up_i    (dec_up),
    .pre_i   (dec_pre),
    .first_o (first_addr),
    .final_o (final_addr)
  );

  blk_xfer_pick #(.NREG(NREG), .IDX_W(IDX_W)) i_pick (
    .list_i (pend_q),
    .idx_o  (pick_idx),
    .rest_o (pick_rest),
    .last_o (pick_last)
  );

  assign beat_go = (state_q == ST_BEAT) & mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pend_q    <= '0;
      addr_q    <= '0;
      wb_val_q  <= '0;
      load_q    <= 1'b0;
      user_q    <= 1'b0;
      restore_q <= 1'b0;
      wb_q      <= 1'b0;
      unpred_q  <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pend_q    <= dec_list;
          addr_q    <= first_addr;
          wb_val_q  <= final_addr;
          load_q    <= dec_load;
          user_q    <= dec_user;
          restore_q <= dec_restore;
          wb_q      <= dec_wb;
          unpred_q  <= dec_unpred;
          abort_q   <= 1'b0;
          state_q   <= dec_unpred ? ST_FIN : ST_BEAT;
        end
        ST_BEAT: if (beat_go) begin
          if (mem_abort_i) begin
            abort_q <= 1'b1;
            state_q <= ST_FIN;
          end else if (pick_last) begin
            pend_q  <= '0;
            state_q <= ST_FIN;
          end else begin
            pend_q <= pick_rest;
            addr_q <= addr_q + AW'(STEP);
          end
        end
        ST_FIN: begin
          unpred_q <= 1'b0;
          abort_q  <= 1'b0;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fin   = (state_q == ST_FIN);
  assign clean = fin & ~unpred_q & ~abort_q;

  assign mem_valid_o      = (state_q == ST_BEAT);
  assign addr_o           = addr_q;
  assign reg_idx_o        = pick_idx;
  assign load_o           = load_q;
  assign user_bank_o      = user_q;
  assign status_restore_o = clean & restore_q;
  assign wb_en_o          = clean & wb_q;
  assign wb_val_o         = wb_val_q;
  assign unpred_o         = fin & unpred_q;
  assign abort_o          = fin & abort_q;
  assign done_o           = fin;

  a_r13_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r12_abort_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (!wb_en_o && !status_restore_o));

  a_r1_unpred_no_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unpred_o |-> !$past(mem_valid_o));

  a_r4_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && $past(mem_valid_o && mem_ready_i)) |-> addr_o == $past(addr_o) + AW'(STEP));

  a_r4_idx_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && $past(mem_valid_o && mem_ready_i)) |-> reg_idx_o > $past(reg_idx_o));

  a_r4_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && $past(mem_valid_o && !mem_ready_i)) |-> ($stable(addr_o) && $stable(reg_idx_o)));

  a_r11_restore_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_restore_o |-> (load_o && !user_bank_o && done_o));
endmodule

// File: tb/test_blk_xfer_seq.sv
module test_blk_xfer_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [31:0] base_i = '0;
  logic        mem_ready_i = 1'b0;
  logic        mem_abort_i = 1'b0;
  logic        mem_valid_o, load_o, user_bank_o, status_restore_o;
  logic        wb_en_o, unpred_o, abort_o, done_o;
  logic [31:0] addr_o, wb_val_o;
  logic [3:0]  reg_idx_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  blk_xfer_seq i_blk_xfer_seq (
    .clk_i, .rst_ni, .start_i, .insn_i, .base_i,
    .mem_valid_o, .mem_ready_i, .mem_abort_i,
    .addr_o, .reg_idx_o, .load_o, .user_bank_o, .status_restore_o,
    .wb_en_o, .wb_val_o, .unpred_o, .abort_o, .done_o
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit p, bit u, bit s, bit w, bit l,
                                     logic [3:0] rn, logic [15:0] lst);
    return {4'hE, 3'b100, p, u, s, w, l, rn, lst};
  endfunction

  function automatic int nth_bit(logic [15:0] lst, int k);
    int c = 0;
    for (int i = 0; i < 16; i++) begin
      if (lst[i]) begin
        if (c == k) return i;
        c++;
      end
    end
    return -1;
  endfunction

  task automatic run(string tag, logic [31:0] insn, logic [31:0] base,
                     bit stall, int abort_at);
    logic [15:0] lst = insn[15:0];
    int n = $countones(lst);
    bit l = insn[20], w = insn[21], s = insn[22], u = insn[23], p = insn[24];
    bit unp = (insn[19:16] == 4'hF) || (n == 0) || (s && w && !lst[15]);
    bit aborted = !unp && abort_at >= 0 && abort_at < n;
    int exp_beats = unp ? 0 : (aborted ? abort_at + 1 : n);
    bit exp_user = s && (!l || !lst[15]);
    bit exp_rest = s && l && lst[15] && !unp && !aborted;
    logic [31:0] first, fin_v;
    int k = 0;
    bit seen = 0;
    if (u) begin first = p ? base + 4 : base; fin_v = base + 32'(4 * n); end
    else begin first = p ? base - 32'(4 * n) : base - 32'(4 * (n - 1)); fin_v = base - 32'(4 * n); end

    @(negedge clk_i);
    insn_i = insn; base_i = base; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int it = 0; it < 200 && !seen; it++) begin
      if (done_o) begin
        seen = 1;
        chk(k == exp_beats, {tag, " R4 beat count"}, 32'(k), 32'(exp_beats));
        chk(!mem_valid_o, {tag, " R13 no beat at done"}, 32'(mem_valid_o), 0);
        chk(unpred_o == unp, {tag, " R1/R2/R3 unpred"}, 32'(unpred_o), 32'(unp));
        chk(abort_o == aborted, {tag, " R12 abort"}, 32'(abort_o), 32'(aborted));
        chk(wb_en_o == (w && !unp && !aborted), {tag, " R9 wb_en"}, 32'(wb_en_o),
            32'(w && !unp && !aborted));
        if (w && !unp && !aborted)
          chk(wb_val_o == fin_v, {tag, " R9 wb_val"}, wb_val_o, fin_v);
        chk(status_restore_o == exp_rest, {tag, " R11 restore"}, 32'(status_restore_o),
            32'(exp_rest));
        @(negedge clk_i);
        chk(!done_o, {tag, " R13 done single"}, 32'(done_o), 0);
      end else if (mem_valid_o) begin
        bit go = stall ? it[0] : 1'b1;
        chk(addr_o == first + 32'(4 * k), {tag, " R4-R8 addr"}, addr_o, first + 32'(4 * k));
        chk(32'(reg_idx_o) == 32'(nth_bit(lst, k)), {tag, " R4 reg order"},
            32'(reg_idx_o), 32'(nth_bit(lst, k)));
        chk(load_o == l, {tag, " R13 load"}, 32'(load_o), 32'(l));
        chk(user_bank_o == exp_user, {tag, " R10 user bank"}, 32'(user_bank_o), 32'(exp_user));
        mem_ready_i = go;
        mem_abort_i = go && (k == abort_at);
        @(negedge clk_i);
        if (go) k++;
        mem_ready_i = 1'b0;
        mem_abort_i = 1'b0;
      end else begin
        @(negedge clk_i);
      end
    end
    chk(seen, {tag, " R13 done seen"}, 32'(seen), 1);
  endtask

  task automatic t_reset;
    chk(!done_o && !mem_valid_o && !wb_en_o && !unpred_o, "R13 reset idle",
        {28'd0, done_o, mem_valid_o, wb_en_o, unpred_o}, 0);
  endtask

  task automatic t_inc_after;  run("R6 IA load", mk(0,1,0,0,1,4'd2,16'h00A5), 32'h1000, 0, -1); endtask
  task automatic t_inc_before; run("R5 IB store wb", mk(1,1,0,1,0,4'd3,16'h8013), 32'h2000, 0, -1); endtask
  task automatic t_dec_before; run("R7 DB load wb", mk(1,0,0,1,1,4'd1,16'h0F00), 32'h3000, 1, -1); endtask
  task automatic t_dec_after1; run("R8 DA single wb", mk(0,0,0,1,0,4'd0,16'h0040), 32'h4000, 0, -1); endtask
  task automatic t_dec_after3; run("R8 DA three", mk(0,0,0,0,1,4'd5,16'h1111), 32'h5000, 1, -1); endtask
  task automatic t_user_store; run("R10 S store", mk(1,1,1,0,0,4'd6,16'h00F0), 32'h6000, 0, -1); endtask
  task automatic t_user_load;  run("R10 S load", mk(0,1,1,0,1,4'd7,16'h0303), 32'h7000, 0, -1); endtask
  task automatic t_restore;    run("R11 S load pc", mk(0,1,1,1,1,4'd13,16'h8001), 32'h8000, 0, -1); endtask
  task automatic t_abort;      run("R12 abort mid", mk(1,1,0,1,1,4'd9,16'h00FF), 32'h9000, 1, 3); endtask
  task automatic t_rn_pc;      run("R1 rn pc", mk(0,1,0,0,1,4'hF,16'h0003), 32'hA000, 0, -1); endtask
  task automatic t_empty;      run("R2 empty", mk(0,1,0,0,1,4'd1,16'h0000), 32'hB000, 0, -1); endtask
  task automatic t_sw_nopc;    run("R3 S+W no pc", mk(0,1,1,1,0,4'd2,16'h0007), 32'hC000, 0, -1); endtask
  task automatic t_full;       run("R4 full list", mk(0,1,0,1,0,4'd4,16'hFFFF), 32'hFFFF_FFF0, 0, -1); endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_inc_after();
    t_inc_before();
    t_dec_before();
    t_dec_after1();
    t_dec_after3();
    t_user_store();
    t_user_load();
    t_restore();
    t_abort();
    t_rn_pc();
    t_empty();
    t_sw_nopc();
    t_full();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule